// File: doc/BRIEF.md
# Pipelined Four-Term Sum of Products

This block takes four pairs of unsigned operands and returns the sum of the four pairwise products. The work is split into three registered stages. The first stage forms all four products side by side. The second stage adds those products in two pairs at the same time. The third stage adds the two pair totals. A new operand set can be taken on every clock, and each result leaves three clocks after its operands entered.

The result is kept at full precision, so no operand values can make it wrap. A valid strobe travels alongside the data. Each stage register loads only when the data it receives is valid, so the output word keeps its value between results. An asynchronous active-low reset clears the valid path and the data registers. Its release is synchronised to the clock inside the block.

Top module: `sop4_pipe`

## Requirements
- R1: When `out_vld` is 1, `result` equals op_a[0]*op_b[0] + op_a[1]*op_b[1] + op_a[2]*op_b[2] + op_a[3]*op_b[3]. Operands are unsigned, and lane i of each packed bus occupies bits [16*i+15:16*i]. This holds for operand sets that include zero operands.
- R2: Operands sampled on a rising edge with `in_vld` = 1 produce `out_vld` = 1 and their `result` right after the third rising edge counted from that one.
- R3: Operand sets applied on consecutive clocks produce independent, correct results on consecutive output clocks. `out_vld` is never 1 without a matching accepted input.
- R4: `result` is 34 bits wide and does not wrap. With all eight operands at 0xFFFF it reads 0x3_FFF8_0004.
- R5: While `out_vld` is 0, `result` holds the last delivered value. Operands presented with `in_vld` = 0 change neither `result` nor `out_vld`.
- R6: While `rst_n` is 0, `out_vld` and `result` are 0 and any operand sets still in flight are discarded. Inputs are accepted again from the third rising edge after `rst_n` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| in_vld | input | 1 | Marks the operand buses as a set to process |
| op_a | input | 64 | Four 16-bit left-hand operands, lane i at bits [16*i+15:16*i] |
| op_b | input | 64 | Four 16-bit right-hand operands, same lane layout |
| out_vld | output | 1 | One-cycle marker for a new `result` |
| result | output | 34 | Sum of the four products, unsigned |

## Verification
The assertions assume that the operand buses are steady and defined whenever `in_vld` is sampled high. They also assume that no operand set is offered during the two clocks in which the internal reset is still held after `rst_n` rises. The stimulus changes inputs only on falling edges. After every reset release it waits three full clocks before raising `in_vld`. It mixes zero, all-ones and random operand sets, including back-to-back bursts and idle gaps carrying junk operands.

// File: rtl/sop_pkg.sv
package sop_pkg;
  localparam int unsigned SOP_LANES = 4;

  function automatic int unsigned sop_res_w(input int unsigned opw);
    return 2 * opw + 2;
  endfunction
endpackage

// File: rtl/sop_rst_sync.sv
module sop_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/sop_mul_stage.sv
module sop_mul_stage #(
  parameter int unsigned OPW   = 16,
  parameter int unsigned LANES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        vld_i,
  input  logic [LANES-1:0][OPW-1:0]   a_i,
  input  logic [LANES-1:0][OPW-1:0]   b_i,
  output logic                        vld_o,
  output logic [LANES-1:0][2*OPW-1:0] prod_o
);
  localparam int unsigned PW = 2 * OPW;

  logic vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_i;
  end
  assign vld_o = vld_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [PW-1:0] prod_d;
    logic [PW-1:0] prod_q;

    always_comb begin
      prod_d = PW'(a_i[g]) * PW'(b_i[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     prod_q <= '0;
      else if (vld_i) prod_q <= prod_d;
    end

    assign prod_o[g] = prod_q;
  end
endmodule

// File: rtl/sop_add_stage.sv
module sop_add_stage #(
  parameter int unsigned W    = 32,
  parameter int unsigned NOUT = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     vld_i,
  input  logic [2*NOUT-1:0][W-1:0] din,
  output logic                     vld_o,
  output logic [NOUT-1:0][W:0]     dout
);
  logic vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_i;
  end
  assign vld_o = vld_q;

  for (genvar g = 0; g < NOUT; g++) begin : g_pair
    logic [W:0] sum_d;
    logic [W:0] sum_q;

    always_comb begin
      sum_d = {1'b0, din[2*g]} + {1'b0, din[2*g+1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sum_q <= '0;
      else if (vld_i) sum_q <= sum_d;
    end

    assign dout[g] = sum_q;
  end
endmodule

// File: rtl/sop4_pipe.sv
module sop4_pipe #(
  parameter int unsigned OPW = 16
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      in_vld,
  input  logic [sop_pkg::SOP_LANES-1:0][OPW-1:0]    op_a,
  input  logic [sop_pkg::SOP_LANES-1:0][OPW-1:0]    op_b,
  output logic                                      out_vld,
  output logic [sop_pkg::sop_res_w(OPW)-1:0]        result
);
  localparam int unsigned LANES = sop_pkg::SOP_LANES;
  localparam int unsigned PW    = 2 * OPW;
  localparam int unsigned SW    = PW + 1;
  localparam int unsigned RW    = sop_pkg::sop_res_w(OPW);

  logic                    rst_s_n;
  logic                    vld_m;
  logic                    vld_p;
  logic                    vld_f;
  logic [LANES-1:0][PW-1:0] prod;
  logic [1:0][SW-1:0]       pair_sum;
  logic [0:0][RW-1:0]       fin_sum;

  sop_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  sop_mul_stage #(.OPW(OPW), .LANES(LANES)) u_mul (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .vld_i  (in_vld),
    .a_i    (op_a),
    .b_i    (op_b),
    .vld_o  (vld_m),
    .prod_o (prod)
  );

  sop_add_stage #(.W(PW), .NOUT(2)) u_pair (
    .clk   (clk),
    .rst_n (rst_s_n),
    .vld_i (vld_m),
    .din   (prod),
    .vld_o (vld_p),
    .dout  (pair_sum)
  );

  sop_add_stage #(.W(SW), .NOUT(1)) u_final (
    .clk   (clk),
    .rst_n (rst_s_n),
    .vld_i (vld_p),
    .din   (pair_sum),
    .vld_o (vld_f),
    .dout  (fin_sum)
  );

  assign out_vld = vld_f;
  assign result  = fin_sum[0];
endmodule

// File: rtl/sop4_pipe_chk.sv
module sop4_pipe_chk #(
  parameter int unsigned OPW = 16
) (
  input logic                                   clk,
  input logic                                   rst_n,
  input logic                                   rst_s_n,
  input logic                                   in_vld,
  input logic [sop_pkg::SOP_LANES-1:0][OPW-1:0] op_a,
  input logic [sop_pkg::SOP_LANES-1:0][OPW-1:0] op_b,
  input logic                                   out_vld,
  input logic [sop_pkg::sop_res_w(OPW)-1:0]     result
);
  localparam int unsigned RW = sop_pkg::sop_res_w(OPW);

  function automatic logic [RW-1:0] ref_sum(
    input logic [sop_pkg::SOP_LANES-1:0][OPW-1:0] a,
    input logic [sop_pkg::SOP_LANES-1:0][OPW-1:0] b);
    logic [RW-1:0] acc;
    acc = '0;
    for (int i = 0; i < sop_pkg::SOP_LANES; i++) acc = acc + RW'(a[i]) * RW'(b[i]);
    return acc;
  endfunction

  // R1 and R4: full-width value three edges after capture
  assert_sum_value_R1: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_vld |-> result == ref_sum($past(op_a, 3), $past(op_b, 3)));

  // R2: every accepted set emerges after three edges
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    in_vld |=> ##2 out_vld);

  // R3: no output without an input three edges earlier
  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_vld |-> $past(in_vld, 3));

  // R5: output word holds between results
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    !out_vld |-> $stable(result));

  // R6: reset forces idle outputs
  assert_reset_idle_R6: assert property (@(posedge clk)
    !rst_n |-> (!out_vld && result == '0));
endmodule

bind sop4_pipe sop4_pipe_chk #(.OPW(OPW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rst_s_n (rst_s_n),
  .in_vld  (in_vld),
  .op_a    (op_a),
  .op_b    (op_b),
  .out_vld (out_vld),
  .result  (result)
);

// File: tb/sim_sop4_pipe.sv
module sim_sop4_pipe;
  localparam int unsigned OPW = 16;
  localparam int unsigned RW  = 2 * OPW + 2;

  logic                clk;
  logic                rst_n;
  logic                in_vld;
  logic [3:0][OPW-1:0] op_a;
  logic [3:0][OPW-1:0] op_b;
  logic                out_vld;
  logic [RW-1:0]       result;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  logic [RW-1:0] last_res;
  logic          done;

  logic [RW-1:0] exp_q[$];
  int            cyc_q[$];
  string         tag_q[$];

  sop4_pipe #(.OPW(OPW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
    .op_a(op_a), .op_b(op_b), .out_vld(out_vld), .result(result)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [RW-1:0] model(input logic [3:0][OPW-1:0] a,
                                          input logic [3:0][OPW-1:0] b);
    logic [63:0] acc;
    acc = 64'd0;
    for (int i = 0; i < 4; i++) acc = acc + 64'(a[i]) * 64'(b[i]);
    return acc[RW-1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [RW-1:0] act,
                     input logic [RW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic push_set(input logic [3:0][OPW-1:0] a,
                          input logic [3:0][OPW-1:0] b, input string tag);
    @(negedge clk);
    in_vld = 1'b1;
    op_a   = a;
    op_b   = b;
    exp_q.push_back(model(a, b));
    cyc_q.push_back(cyc);
    tag_q.push_back(tag);
  endtask

  // R5: junk operands with in_vld low must leave no trace
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0;
      op_a   = {$urandom(), $urandom()};
      op_b   = {$urandom(), $urandom()};
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_vld) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 spurious out_vld", result, '0);
        end else begin
          logic [RW-1:0] e;
          int            c;
          string         t;
          e = exp_q.pop_front();
          c = cyc_q.pop_front();
          t = tag_q.pop_front();
          chk(result == e, t, result, e);
          chk(cyc == c + 3, "R2 latency", RW'(cyc - c), RW'(3));
        end
        last_res = result;
      end else begin
        chk(result == last_res, "R5 hold", result, last_res);
      end
    end
  end

  task automatic do_reset();
    @(posedge clk);
    #2 rst_n = 1'b0;
    in_vld = 1'b0;
    exp_q.delete();
    cyc_q.delete();
    tag_q.delete();
    last_res = '0;
    @(negedge clk);
    // R6: idle outputs while reset is low
    chk(out_vld == 1'b0, "R6 out_vld in reset", RW'(out_vld), '0);
    chk(result == '0, "R6 result in reset", result, '0);
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    done = 1'b0;
    rst_n = 1'b0;
    in_vld = 1'b0;
    op_a = '0;
    op_b = '0;
    last_res = '0;
    do_reset();

    // R1: simple values and zero operands
    push_set({16'd4, 16'd3, 16'd2, 16'd1}, {16'd8, 16'd7, 16'd6, 16'd5}, "R1 small");
    push_set({16'd0, 16'hFFFF, 16'd0, 16'h1234}, {16'hFFFF, 16'd0, 16'd9, 16'd0}, "R1 zeros");
    idle(5);
    // R4: all operands at maximum
    push_set({4{16'hFFFF}}, {4{16'hFFFF}}, "R4 max");
    idle(4);
    chk(last_res == 34'h3_FFF8_0004, "R4 max value", last_res, 34'h3_FFF8_0004);
    // R3: back-to-back burst
    for (int i = 0; i < 40; i++)
      push_set({$urandom(), $urandom()}, {$urandom(), $urandom()}, "R3 burst");
    // R5: sparse traffic with junk between sets
    for (int i = 0; i < 30; i++) begin
      push_set({$urandom(), $urandom()}, {$urandom(), $urandom()}, "R5 sparse");
      idle(1 + (i % 4));
    end
    idle(5);
    // R6: reset with sets in flight discards them
    push_set({4{16'h00AA}}, {4{16'h0055}}, "R6 flushed");
    push_set({4{16'h0011}}, {4{16'h0022}}, "R6 flushed");
    do_reset();
    idle(4);
    chk(out_vld == 1'b0 && result == '0, "R6 flushed sets absent", result, '0);
    push_set({16'd10, 16'd20, 16'd30, 16'd40}, {16'd1, 16'd2, 16'd3, 16'd4}, "R6 after reset");
    idle(6);
    chk(exp_q.size() == 0, "R2 all results delivered", RW'(exp_q.size()), '0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule